// File: doc/BRIEF.md
# Cascadable 3x3 Image Convolver

This block filters an 8-bit raster stream with a 3x3 kernel of signed 8-bit weights. It returns one 20-bit signed result for each accepted pixel. The bottom kernel row always comes from the pixel input. The two upper rows come from one of two sources, chosen by a configuration bit. The first source is a pair of on-block line delays whose length is set by a row-length register. The second is a 16-bit cascade input that external row buffers or an upstream instance drive.

A programmable delay of 0 to 3 clocks sits on the pixel path. It lets partial sums from several tiled instances arrive in step. An 8-bit cascade output carries the line-delayed pixel to a downstream instance. A large kernel can be split across instances by zeroing rows of each coefficient set and adding their outputs.

Top module: `conv3x3_cascade`

## Requirements
- R1: After a synchronous reset the following hold: `dValid` and `casOut` are 0, all nine coefficients are 0, the mode is cascade, the input delay is 0 and the row length is 1024.
- R2: A pulse on `cfgWe` loads `cfgData`, and the new setting applies from the next clock. Bit 0 selects the source of the upper rows: 1 means internal line delays, 0 means the cascade input. Bits 2:1 set the pixel input delay D, from 0 to 3 clocks.
- R3: A pulse on `coefWe` with `coefAddr` in 0..8 stores `coefData` as weight k = 3*row + col. Row 0 is the top row. Col 0 is the newest sample, col 1 the one before it, col 2 the one before that. A write to addresses 9..15 changes nothing.
- R4: A valid result equals the sum over the nine taps of weight(k) times pixel. Each weight is two's complement and each pixel is unsigned. The result is exact in 20 bits and can never overflow.
- R5: A pixel accepted at clock edge k yields its result and a high `dValid` after edge k+2+D. `dValid` is high for that one cycle only.
- R6: The input delay applies only to `pixIn`, `pixValid` and `pixSof`. In cascade mode `casIn` is sampled, without delay, at the edge where the delayed pixel enters the window.
- R7: In internal mode the middle row is the pixel in the same column of the previous row of the frame, and the top row is the pixel in that column two rows back. Columns count from 0 at `pixSof` and wrap at the programmed row length.
- R8: In internal mode, results for rows 0 and 1 of every frame have `dValid` low.
- R9: In cascade mode the middle row is `casIn[7:0]` and the top row is `casIn[15:8]`, and every accepted pixel yields a valid result.
- R10: At the edge where a delayed pixel is accepted, `casOut` takes the pixel from the same column of the previous row, as held in the internal line delay. This happens in both modes. At all other edges `casOut` holds its value.
- R11: A pulse on `rowLenWe` loads a row length of 1 to 1024 and restarts the column and row count.
- R12: A cycle with `pixValid` low advances no window, line delay or counter, and yields no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 3 | Bit 0 selects the row source; bits 2:1 set the input delay |
| rowLenWe | input | 1 | Row length write strobe |
| rowLen | input | 11 | Row length in pixels, 1..1024 |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 4 | Coefficient index |
| coefData | input | 8 | Signed coefficient value |
| pixValid | input | 1 | Pixel qualifier |
| pixSof | input | 1 | Marks the first pixel of a frame |
| pixIn | input | 8 | Unsigned pixel (bottom row) |
| casIn | input | 16 | Cascade rows: [7:0] middle, [15:8] top |
| casOut | output | 8 | Line-delayed pixel for a downstream instance |
| dOut | output | 20 | Signed filter result |
| dValid | output | 1 | Result qualifier |

## Verification
The assertions take four things for granted. The row length is never written as 0. Changes to configuration and row length happen only between frames. Every frame starts with `pixSof` on its first valid pixel. `casIn` is valid at the edge where the delayed pixel enters the window. The stimulus keeps to these rules: it idles the stream before each write to configuration or row length, and it asserts `pixSof` at row 0, column 0 of each frame. It also drives fresh `casIn` values on every cycle, so the reference model, which samples `casIn` at the delayed edge, exposes any misalignment.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int DLY_MAX   = 3;
  localparam int DLY_SEL_W = $clog2(DLY_MAX + 1);

  typedef struct packed {
    logic                 adv;
    logic                 modeInt;
    logic [DLY_SEL_W-1:0] dlySel;
    logic                 winValid;
  } ctl_t;
endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_pkg::*;
#(
  parameter int LINE_MAX = 1024,
  localparam int COL_W   = $clog2(LINE_MAX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWe,
  input  logic [2:0]       cfgData,
  input  logic             rowLenWe,
  input  logic [COL_W:0]   rowLen,
  input  logic             pixValid,
  input  logic             pixSof,
  output ctl_t             ctl,
  output logic [COL_W-1:0] col
);
  logic                 cfgMode;
  logic [DLY_SEL_W-1:0] cfgDly;
  logic [COL_W-1:0]     lenM1;
  logic [DLY_MAX:1]     vReg, sReg;
  logic [DLY_MAX:0]     vTap, sTap;
  logic                 pdV, pdS;
  logic [COL_W-1:0]     colCnt, curCol;
  logic [1:0]           rowCnt, curRow;
  logic                 lastCol, winValid;
  logic [COL_W:0]       lenM1Full;

  assign vTap      = {vReg, pixValid};
  assign sTap      = {sReg, pixSof};
  assign pdV       = vTap[cfgDly];
  assign pdS       = sTap[cfgDly];
  assign curCol    = pdS ? '0 : colCnt;
  assign curRow    = pdS ? 2'd0 : rowCnt;
  assign lastCol   = (curCol == lenM1);
  assign lenM1Full = rowLen - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgMode  <= 1'b0;
      cfgDly   <= '0;
      lenM1    <= COL_W'(LINE_MAX - 1);
      vReg     <= '0;
      sReg     <= '0;
      colCnt   <= '0;
      rowCnt   <= 2'd0;
      winValid <= 1'b0;
    end else begin
      vReg     <= vTap[DLY_MAX-1:0];
      sReg     <= sTap[DLY_MAX-1:0];
      winValid <= pdV && (!cfgMode || curRow == 2'd2);
      if (pdV) begin
        colCnt <= lastCol ? '0 : curCol + 1'b1;
        rowCnt <= (lastCol && curRow != 2'd2) ? curRow + 2'd1 : curRow;
      end
      if (cfgWe) begin
        cfgMode <= cfgData[0];
        cfgDly  <= cfgData[2:1];
      end
      if (rowLenWe) begin
        lenM1  <= lenM1Full[COL_W-1:0];
        colCnt <= '0;
        rowCnt <= 2'd0;
      end
    end
  end

  assign ctl.adv      = pdV;
  assign ctl.modeInt  = cfgMode;
  assign ctl.dlySel   = cfgDly;
  assign ctl.winValid = winValid;
  assign col          = curCol;

  AST_FIRST_ROWS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pdV && pdS && cfgMode) |=> !winValid); // R8
  AST_CASC_EVERY_PIXEL: assert property (@(posedge clk) disable iff (rst)
    (pdV && !cfgMode) |=> winValid); // R9
  AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (rst)
    curCol <= lenM1); // R11
endmodule

// File: rtl/conv_dp.sv
module conv_dp
  import conv_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 8,
  parameter int OUT_W    = 20,
  parameter int LINE_MAX = 1024,
  localparam int COL_W   = $clog2(LINE_MAX),
  localparam int NTAP    = 9,
  localparam int PROD_W  = PIX_W + COEF_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctl_t                     ctl,
  input  logic [COL_W-1:0]         col,
  input  logic [PIX_W-1:0]         pixIn,
  input  logic [2*PIX_W-1:0]       casIn,
  input  logic                     coefWe,
  input  logic [3:0]               coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic signed [OUT_W-1:0]  dOut,
  output logic                     dValid,
  output logic [PIX_W-1:0]         casOut
);
  localparam int BOUND = NTAP * ((1 << PIX_W) - 1) * (1 << (COEF_W - 1));

  logic [PIX_W-1:0]         pReg  [1:DLY_MAX];
  logic [PIX_W-1:0]         pTap  [0:DLY_MAX];
  logic [PIX_W-1:0]         lineA [LINE_MAX];
  logic [PIX_W-1:0]         lineB [LINE_MAX];
  logic [PIX_W-1:0]         win   [3][3];
  logic [PIX_W-1:0]         newRow [3];
  logic signed [COEF_W-1:0] coefR [NTAP];
  logic signed [PROD_W-1:0] prodR [NTAP];
  logic signed [OUT_W-1:0]  acc;
  logic [PIX_W-1:0]         pd, rdA, rdB;
  logic                     vPipe;

  always_comb begin
    pTap[0] = pixIn;
    for (int i = 1; i <= DLY_MAX; i++) pTap[i] = pReg[i];
  end

  assign pd  = pTap[ctl.dlySel];
  assign rdA = lineA[col];
  assign rdB = lineB[col];

  always_comb begin
    newRow[2] = pd;
    newRow[1] = ctl.modeInt ? rdA : casIn[PIX_W-1:0];
    newRow[0] = ctl.modeInt ? rdB : casIn[2*PIX_W-1:PIX_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= DLY_MAX; i++) pReg[i] <= '0;
      for (int a = 0; a < LINE_MAX; a++) begin
        lineA[a] <= '0;
        lineB[a] <= '0;
      end
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++) win[r][c] <= '0;
      casOut <= '0;
    end else begin
      pReg[1] <= pixIn;
      for (int i = 2; i <= DLY_MAX; i++) pReg[i] <= pReg[i-1];
      if (ctl.adv) begin
        lineA[col] <= pd;
        lineB[col] <= rdA;
        casOut     <= rdA;
        for (int r = 0; r < 3; r++) begin
          win[r][2] <= win[r][1];
          win[r][1] <= win[r][0];
          win[r][0] <= newRow[r];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAP; k++) coefR[k] <= '0;
    end else if (coefWe && coefAddr < 4'(NTAP)) begin
      coefR[coefAddr] <= coefData;
    end
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) prodR[t] <= '0;
      else     prodR[t] <= PROD_W'(coefR[t]) *
                           PROD_W'($signed({1'b0, win[t/3][t%3]}));
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++) acc = acc + OUT_W'(prodR[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vPipe  <= 1'b0;
      dValid <= 1'b0;
      dOut   <= '0;
    end else begin
      vPipe  <= ctl.winValid;
      dValid <= vPipe;
      dOut   <= acc;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    dValid |-> (int'(dOut) <= BOUND && int'(dOut) >= -BOUND)); // R4
  AST_CASOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.adv |=> $stable(casOut)); // R10
endmodule

// File: rtl/conv3x3_cascade.sv
module conv3x3_cascade
  import conv_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int COEF_W   = 8,
  parameter int OUT_W    = 20,
  parameter int LINE_MAX = 1024,
  localparam int COL_W   = $clog2(LINE_MAX)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfgWe,
  input  logic [2:0]               cfgData,
  input  logic                     rowLenWe,
  input  logic [COL_W:0]           rowLen,
  input  logic                     coefWe,
  input  logic [3:0]               coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  input  logic                     pixValid,
  input  logic                     pixSof,
  input  logic [PIX_W-1:0]         pixIn,
  input  logic [2*PIX_W-1:0]       casIn,
  output logic [PIX_W-1:0]         casOut,
  output logic signed [OUT_W-1:0]  dOut,
  output logic                     dValid
);
  ctl_t             ctl;
  logic [COL_W-1:0] col;

  conv_ctrl #(.LINE_MAX(LINE_MAX)) u_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgData(cfgData),
    .rowLenWe(rowLenWe), .rowLen(rowLen), .pixValid(pixValid),
    .pixSof(pixSof), .ctl(ctl), .col(col)
  );

  conv_dp #(.PIX_W(PIX_W), .COEF_W(COEF_W), .OUT_W(OUT_W),
            .LINE_MAX(LINE_MAX)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .col(col), .pixIn(pixIn),
    .casIn(casIn), .coefWe(coefWe), .coefAddr(coefAddr),
    .coefData(coefData), .dOut(dOut), .dValid(dValid), .casOut(casOut)
  );
endmodule

// File: tb/conv3x3_cascade_bench.sv
module conv3x3_cascade_bench;
  logic        clk = 0, rst = 1;
  logic        cfgWe = 0, rowLenWe = 0, coefWe = 0;
  logic [2:0]  cfgData = 0;
  logic [10:0] rowLen = 0;
  logic [3:0]  coefAddr = 0;
  logic signed [7:0] coefData = 0;
  logic        pixValid = 0, pixSof = 0;
  logic [7:0]  pixIn = 0;
  logic [15:0] casIn = 0;
  logic [7:0]  casOut;
  logic signed [19:0] dOut;
  logic        dValid;

  int errs = 0, checks = 0;
  bit done = 0;
  string tagD = "R1", tagV = "R1";

  conv3x3_cascade u_conv3x3_cascade (.*);

  always #10 clk = ~clk;

  // behavioural reference
  int lm1 [1024], lm2 [1024];
  int win [3][3];
  int coefM [9];
  int modeM, dlyM, lenM, colM, rowM, expCas, edgeN;
  int hv [4], hp [4], hs [4];
  int slotV [8], slotD [8];

  always @(posedge clk) begin
    int ev, ep, es, cl, rw, mid, top, sum;
    edgeN++;
    if (rst) begin
      foreach (lm1[i]) begin lm1[i] = 0; lm2[i] = 0; end
      foreach (win[r, c]) win[r][c] = 0;
      foreach (coefM[i]) coefM[i] = 0;
      foreach (hv[i]) begin hv[i] = 0; hp[i] = 0; hs[i] = 0; end
      modeM = 0; dlyM = 0; lenM = 1024; colM = 0; rowM = 0; expCas = 0;
      slotV[(edgeN + 2) % 8] = 0;
    end else begin
      hv[0] = pixValid; hp[0] = pixIn; hs[0] = pixSof;
      ev = hv[dlyM]; ep = hp[dlyM]; es = hs[dlyM];
      slotV[(edgeN + 2) % 8] = 0;
      if (ev != 0) begin
        cl = es ? 0 : colM;
        rw = es ? 0 : rowM;
        mid = modeM ? lm1[cl] : int'(casIn[7:0]);
        top = modeM ? lm2[cl] : int'(casIn[15:8]);
        expCas = lm1[cl];
        lm2[cl] = lm1[cl];
        lm1[cl] = ep;
        for (int r = 0; r < 3; r++) begin
          win[r][2] = win[r][1]; win[r][1] = win[r][0];
        end
        win[0][0] = top; win[1][0] = mid; win[2][0] = ep;
        sum = 0;
        for (int k = 0; k < 9; k++) sum += coefM[k] * win[k / 3][k % 3];
        slotV[(edgeN + 2) % 8] = (modeM == 0 || rw >= 2) ? 1 : 0;
        slotD[(edgeN + 2) % 8] = sum;
        if (cl == lenM - 1) begin colM = 0; rowM = (rw >= 2) ? 2 : rw + 1; end
        else begin colM = cl + 1; rowM = rw; end
      end
      for (int i = 3; i >= 1; i--) begin hv[i] = hv[i-1]; hp[i] = hp[i-1]; hs[i] = hs[i-1]; end
      if (cfgWe) begin modeM = cfgData[0]; dlyM = cfgData[2:1]; end
      if (coefWe && coefAddr < 9) coefM[coefAddr] = int'(coefData);
      if (rowLenWe) begin lenM = rowLen; colM = 0; rowM = 0; end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (dValid !== slotV[edgeN % 8][0]) begin
        errs++;
        $display("FAIL %s dValid act=%0d exp=%0d", tagV, dValid, slotV[edgeN % 8]);
      end
      if (slotV[edgeN % 8] != 0) begin
        checks++;
        if (int'(dOut) != slotD[edgeN % 8]) begin
          errs++;
          $display("FAIL %s dOut act=%0d exp=%0d", tagD, dOut, slotD[edgeN % 8]);
        end
      end
      checks++;
      if (int'(casOut) != expCas) begin
        errs++;
        $display("FAIL R10 casOut act=%0d exp=%0d", casOut, expCas);
      end
    end
  end

  task automatic drive(bit v, bit s, logic [7:0] p, logic [15:0] c);
    pixValid = v; pixSof = s; pixIn = p; casIn = c;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) drive(0, 0, 8'($urandom), 16'($urandom));
  endtask

  task automatic setCfg(bit mode, int dly);
    cfgWe = 1; cfgData = {2'(dly), mode};
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic setLen(int len);
    rowLenWe = 1; rowLen = 11'(len);
    @(negedge clk);
    rowLenWe = 0;
  endtask

  task automatic setCoef(int a, int d);
    coefWe = 1; coefAddr = 4'(a); coefData = 8'(d);
    @(negedge clk);
    coefWe = 0;
  endtask

  task automatic randCoefs();
    for (int k = 0; k < 9; k++) setCoef(k, $urandom_range(255));
  endtask

  task automatic frame(int rows, int len, bit gaps, bit badWrites);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < len; c++) begin
        if (gaps && $urandom_range(3) == 0) drive(0, 1, 8'($urandom), 16'($urandom));
        if (badWrites) begin
          coefWe = 1; coefAddr = 4'($urandom_range(15, 9)); coefData = 8'($urandom);
        end
        drive(1, r == 0 && c == 0, 8'($urandom), 16'($urandom));
        coefWe = 0;
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    checks++;
    if (dValid !== 1'b0 || casOut !== 8'd0) begin
      errs++;
      $display("FAIL R1 reset act=%0d/%0d exp=0/0", dValid, casOut);
    end
    // R1: default cascade mode, zero weights
    tagD = "R1"; tagV = "R9";
    frame(1, 6, 0, 0);
    idle(5);
    // R4 R9 R5: cascade mode, random weights, D=0
    randCoefs();
    tagD = "R4"; tagV = "R5";
    frame(1, 20, 0, 0);
    idle(5);
    // R2 R6: delay 2 in cascade mode, casIn sampled at delayed edge
    setCfg(0, 2); idle(4);
    tagD = "R6"; tagV = "R2";
    frame(1, 20, 0, 0);
    idle(6);
    // R12: gaps in the stream
    tagD = "R12"; tagV = "R12";
    frame(1, 30, 1, 0);
    idle(6);
    // R4 boundaries: maximal magnitudes
    setCfg(0, 0); idle(4);
    for (int k = 0; k < 9; k++) setCoef(k, 127);
    tagD = "R4"; tagV = "R5";
    repeat (6) drive(1, 0, 8'hff, 16'hffff);
    idle(4);
    for (int k = 0; k < 9; k++) setCoef(k, -128);
    repeat (6) drive(1, 0, 8'hff, 16'hffff);
    idle(4);
    // R3: writes to 9..15 ignored during streaming
    randCoefs();
    tagD = "R3"; tagV = "R5";
    frame(1, 20, 0, 1);
    idle(5);
    // R7 R8: internal mode, length 5, D=1
    setLen(5); setCfg(1, 1); idle(4);
    tagD = "R7"; tagV = "R8";
    frame(5, 5, 1, 0);
    frame(3, 5, 0, 0);
    idle(6);
    // R11: new row length 4, D=3
    setLen(4); setCfg(1, 3); idle(5);
    tagD = "R11"; tagV = "R11";
    frame(6, 4, 1, 0);
    idle(6);
    // R10: line delay observed while in cascade mode
    setCfg(0, 1); idle(4);
    tagD = "R9"; tagV = "R9";
    frame(3, 4, 0, 0);
    idle(8);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule